// File: doc/BRIEF.md
# Nonvolatile Shadow SRAM Controller

This block models a small byte-wide static RAM in which every byte has a paired nonvolatile shadow cell. A host reads and writes the volatile array through a simple single-cycle port. Two whole-array transfers move data between the two arrays. STORE copies every byte into its shadow. RECALL copies every shadow byte back into the RAM. Each transfer takes a fixed, parameterised number of cycles, and the whole array moves at once when the transfer ends.

A level input `supply_ok` models the supply monitor. When it rises while the block is unpowered, a RECALL runs automatically before the host may access the array. When it falls during normal operation, an automatic STORE runs, but only if a write has completed since the last transfer. Software can also request a STORE, which always runs, or a RECALL. While a transfer runs, the block reports busy and rejects host accesses with an error strobe. A saturating counter tracks how many STOREs the shadow array has absorbed and raises a wear-out flag at the rated limit.

Top module: `nvshadow_ctrl`

## Requirements
- R1: In the ready state, a write with `host_en`=1 and `host_we`=1 updates the addressed byte at the clock edge. A read with `host_en`=1 and `host_we`=0 returns that byte on `host_rdata` in the same cycle.
- R2: After reset the block is unpowered: `ready`, `busy`, `done`, `dirty` and `wear_out` are 0, `store_count` is 0, and both arrays hold all zeros.
- R3: When `supply_ok` is 1 while the block is unpowered, a RECALL starts at the next edge. When it ends, `ready` is 1 and the RAM holds the shadow contents.
- R4: A software STORE (`sw_store`=1 while ready) copies every RAM byte to the shadow array. It runs even when `dirty` is 0.
- R5: A software RECALL (`sw_recall`=1 while ready) overwrites every RAM byte with its shadow byte, discarding writes made since the last STORE.
- R6: When `supply_ok` is 0 while ready and `dirty` is 1, an automatic STORE runs and the block then becomes unpowered. A write in that same cycle counts as dirty and is included in the store.
- R7: When `supply_ok` is 0 while ready and `dirty` is 0, no STORE runs: the block goes unpowered at the next edge with `busy` low, and `store_count` does not change.
- R8: `dirty` becomes 1 after every accepted host write and returns to 0 when any STORE or RECALL completes.
- R9: Every transfer holds `busy` high for exactly XFER_CYCLES consecutive cycles. `done` is high for exactly one cycle, the last busy cycle.
- R10: A host access while not ready is ignored and raises `host_err` in that cycle. `host_rdata` is 0 whenever not ready.
- R11: Software requests that arrive during a transfer are dropped. A falling `supply_ok` takes priority over a software request in the same cycle, and STORE takes priority over RECALL when both are requested together.
- R12: `store_count` increments when each STORE completes and saturates at STORE_LIMIT. `wear_out` is 1 exactly when the count equals STORE_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both arrays |
| supply_ok | input | 1 | Supply monitor level; 0 means power failing |
| sw_store | input | 1 | Software STORE request |
| sw_recall | input | 1 | Software RECALL request |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, zero when not ready |
| host_err | output | 1 | Access rejected this cycle |
| ready | output | 1 | Host access allowed |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last cycle of a transfer |
| dirty | output | 1 | Write since last transfer |
| store_count | output | $clog2(STORE_LIMIT+1) | Saturating STORE count |
| wear_out | output | 1 | Store limit reached |

## Verification
The transfers are exercised with distinct byte patterns, which makes a STORE distinguishable from a skipped one and a RECALL distinguishable from retained writes. The power-fail path is tried both with a clean array, where the store must be skipped, and with a write landing in the very cycle the supply drops, where that byte must survive a power cycle. Requests are collided on purpose: a software store during a recall, a recall together with a supply drop, and store together with recall. The surviving data afterwards shows which request won. A small store limit lets saturation and wear-out be reached in a short run.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      NVS_OFF    = 2'd0,
      NVS_RECALL = 2'd1,
      NVS_READY  = 2'd2,
      NVS_STORE  = 2'd3
   } nvs_state_e;
endpackage

// File: rtl/nvs_seq.sv
module nvs_seq
   import nvs_pkg::*;
#(
   parameter int XFER_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic sw_store,
   input  logic sw_recall,
   input  logic wr_fire,
   output logic ready,
   output logic busy,
   output logic done,
   output logic dirty,
   output logic nv_load,
   output logic ram_load
);
   localparam int CW = $clog2(XFER_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(XFER_CYCLES - 1);

   nvs_state_e state_q;
   logic [CW-1:0] cnt_q;
   logic auto_q;
   logic dirty_q;
   logic last;

   assign last  = (cnt_q == LAST);
   assign ready = (state_q == NVS_READY);
   assign busy  = (state_q == NVS_STORE) || (state_q == NVS_RECALL);
   assign done  = busy && last;
   assign dirty = dirty_q;
   assign nv_load  = (state_q == NVS_STORE) && last;
   assign ram_load = (state_q == NVS_RECALL) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= NVS_OFF;
         cnt_q   <= '0;
         auto_q  <= 1'b0;
         dirty_q <= 1'b0;
      end else begin
         case (state_q)
            NVS_OFF: begin
               if (supply_ok) begin
                  state_q <= NVS_RECALL;
                  cnt_q   <= '0;
               end
            end
            NVS_READY: begin
               if (wr_fire) dirty_q <= 1'b1;
               if (!supply_ok) begin
                  if (dirty_q || wr_fire) begin
                     state_q <= NVS_STORE;
                     auto_q  <= 1'b1;
                     cnt_q   <= '0;
                  end else begin
                     state_q <= NVS_OFF;
                  end
               end else if (sw_store) begin
                  state_q <= NVS_STORE;
                  auto_q  <= 1'b0;
                  cnt_q   <= '0;
               end else if (sw_recall) begin
                  state_q <= NVS_RECALL;
                  cnt_q   <= '0;
               end
            end
            default: begin
               if (last) begin
                  cnt_q   <= '0;
                  dirty_q <= 1'b0;
                  state_q <= (state_q == NVS_STORE && auto_q) ? NVS_OFF : NVS_READY;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/nvs_cells.sv
module nvs_cells #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              nv_load,
   input  logic              ram_load,
   output logic [DATA_W-1:0] rd_byte
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH*DATA_W-1:0] ram_flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [DATA_W-1:0] vol_q;
      logic [DATA_W-1:0] shd_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vol_q <= '0;
            shd_q <= '0;
         end else begin
            if (ram_load)
               vol_q <= shd_q;
            else if (wr_fire && (addr == ADDR_W'(i)))
               vol_q <= wdata;
            if (nv_load)
               shd_q <= vol_q;
         end
      end

      assign ram_flat[i*DATA_W +: DATA_W] = vol_q;
   end

   assign rd_byte = ram_flat[addr*DATA_W +: DATA_W];
endmodule

// File: rtl/nvs_wear.sv
module nvs_wear #(
   parameter int STORE_LIMIT = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bump,
   output logic [$clog2(STORE_LIMIT+1)-1:0] count,
   output logic worn
);
   localparam int SW = $clog2(STORE_LIMIT + 1);
   localparam logic [SW-1:0] LIM = SW'(STORE_LIMIT);

   logic [SW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (bump && (cnt_q != LIM))
         cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;
   assign worn  = (cnt_q == LIM);
endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl #(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int XFER_CYCLES = 16,
   parameter int STORE_LIMIT = 200000
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               supply_ok,
   input  logic                               sw_store,
   input  logic                               sw_recall,
   input  logic                               host_en,
   input  logic                               host_we,
   input  logic [ADDR_W-1:0]                  host_addr,
   input  logic [DATA_W-1:0]                  host_wdata,
   output logic [DATA_W-1:0]                  host_rdata,
   output logic                               host_err,
   output logic                               ready,
   output logic                               busy,
   output logic                               done,
   output logic                               dirty,
   output logic [$clog2(STORE_LIMIT+1)-1:0]   store_count,
   output logic                               wear_out
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("nvshadow_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("nvshadow_ctrl: DATA_W must be positive");
   end
   if (XFER_CYCLES < 2) begin : g_bad_xfer
      $error("nvshadow_ctrl: XFER_CYCLES must be at least 2");
   end
   if (STORE_LIMIT < 1) begin : g_bad_lim
      $error("nvshadow_ctrl: STORE_LIMIT must be positive");
   end

   logic wr_fire;
   logic rd_fire;
   logic nv_load;
   logic ram_load;
   logic [DATA_W-1:0] rd_byte;

   assign wr_fire    = host_en && host_we && ready;
   assign rd_fire    = host_en && !host_we && ready;
   assign host_err   = host_en && !ready;
   assign host_rdata = rd_fire ? rd_byte : '0;

   nvs_seq #(.XFER_CYCLES(XFER_CYCLES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .supply_ok(supply_ok),
      .sw_store (sw_store),
      .sw_recall(sw_recall),
      .wr_fire  (wr_fire),
      .ready    (ready),
      .busy     (busy),
      .done     (done),
      .dirty    (dirty),
      .nv_load  (nv_load),
      .ram_load (ram_load)
   );

   nvs_cells #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (wr_fire),
      .addr    (host_addr),
      .wdata   (host_wdata),
      .nv_load (nv_load),
      .ram_load(ram_load),
      .rd_byte (rd_byte)
   );

   nvs_wear #(.STORE_LIMIT(STORE_LIMIT)) u_wear (
      .clk  (clk),
      .rst_n(rst_n),
      .bump (nv_load),
      .count(store_count),
      .worn (wear_out)
   );
endmodule

// File: rtl/nvshadow_ctrl_chk.sv
module nvshadow_ctrl_chk #(
   parameter int DATA_W = 8,
   parameter int SCW    = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_en,
   input logic              host_we,
   input logic [DATA_W-1:0] host_rdata,
   input logic              host_err,
   input logic              ready,
   input logic              busy,
   input logic              done,
   input logic              dirty,
   input logic [SCW-1:0]    store_count,
   input logic              wear_out
);
   assert_blocked_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en && busy) |-> (host_err && host_rdata == '0));

   assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_dirty_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en && host_we && ready) |=> dirty);

   assert_dirty_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !dirty);

   assert_wear_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wear_out |=> wear_out);

   assert_count_monotone_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> (store_count >= $past(store_count)));

   assert_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !busy);
endmodule

bind nvshadow_ctrl nvshadow_ctrl_chk #(
   .DATA_W(DATA_W),
   .SCW($clog2(STORE_LIMIT+1))
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_en    (host_en),
   .host_we    (host_we),
   .host_rdata (host_rdata),
   .host_err   (host_err),
   .ready      (ready),
   .busy       (busy),
   .done       (done),
   .dirty      (dirty),
   .store_count(store_count),
   .wear_out   (wear_out)
);

// File: tb/tb_nvshadow_ctrl.sv
module tb_nvshadow_ctrl;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int XC = 4;
   localparam int LIM = 3;
   localparam int SCW = $clog2(LIM + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0;
   logic sw_store = 1'b0;
   logic sw_recall = 1'b0;
   logic host_en = 1'b0;
   logic host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic host_err, ready, busy, done, dirty, wear_out;
   logic [SCW-1:0] store_count;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   nvshadow_ctrl #(.ADDR_W(AW), .DATA_W(DW), .XFER_CYCLES(XC), .STORE_LIMIT(LIM)) dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sw_store(sw_store),
      .sw_recall(sw_recall), .host_en(host_en), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_err(host_err), .ready(ready), .busy(busy), .done(done), .dirty(dirty),
      .store_count(store_count), .wear_out(wear_out)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_write(input int a, input int d);
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b1;
      host_addr = AW'(a); host_wdata = DW'(d);
      @(negedge clk);
      host_en = 1'b0; host_we = 1'b0;
   endtask

   task automatic do_read(input int a, output int d, output int err);
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
      #1;
      d = int'(host_rdata); err = int'(host_err);
      host_en = 1'b0;
   endtask

   task automatic wait_idle(output int nb, output int nd);
      nb = 0; nd = 0;
      while (busy === 1'b1 && nb < 100) begin
         nb++;
         if (done === 1'b1) nd++;
         @(negedge clk);
      end
   endtask

   task automatic pulse(input bit st, input bit rc, input bit drop);
      @(negedge clk);
      sw_store = st; sw_recall = rc;
      if (drop) supply_ok = 1'b0;
      @(negedge clk);
      sw_store = 1'b0; sw_recall = 1'b0;
   endtask

   task automatic t_reset();
      check("R2", "ready", int'(ready), 0);
      check("R2", "busy", int'(busy), 0);
      check("R2", "dirty", int'(dirty), 0);
      check("R2", "wear", int'(wear_out), 0);
      check("R2", "count", int'(store_count), 0);
   endtask

   task automatic t_power_up(input string req);
      int nb, nd;
      @(negedge clk);
      supply_ok = 1'b1;
      @(negedge clk);
      wait_idle(nb, nd);
      check(req, "recall busy cycles", nb, XC);
      check("R9", "recall done pulses", nd, 1);
      check(req, "ready after recall", int'(ready), 1);
   endtask

   task automatic t_blank_fill();
      int d, e;
      do_read(6, d, e);
      check("R3", "blank shadow recalled", d, 0);
      for (int i = 0; i < 8; i++) do_write(i, 8'hA0 + i);
      check("R8", "dirty after write", int'(dirty), 1);
      for (int i = 0; i < 8; i++) begin
         do_read(i, d, e);
         check("R1", $sformatf("readback %0d", i), d, 8'hA0 + i);
      end
      check("R1", "no err when ready", e, 0);
   endtask

   task automatic t_sw_store_recall();
      int nb, nd, d, e;
      pulse(1'b1, 1'b0, 1'b0);
      wait_idle(nb, nd);
      check("R9", "store busy cycles", nb, XC);
      check("R12", "count after store", int'(store_count), 1);
      check("R8", "dirty cleared by store", int'(dirty), 0);
      do_write(2, 8'h55);
      pulse(1'b0, 1'b1, 1'b0);
      wait_idle(nb, nd);
      do_read(2, d, e);
      check("R5", "recall discards write", d, 8'hA2);
      check("R8", "dirty cleared by recall", int'(dirty), 0);
      pulse(1'b1, 1'b0, 1'b0);
      wait_idle(nb, nd);
      check("R4", "clean store still runs", nb, XC);
      check("R4", "count after clean store", int'(store_count), 2);
   endtask

   task automatic t_busy_access();
      int nb, nd, d, e;
      pulse(1'b0, 1'b1, 1'b0);
      check("R9", "busy after request", int'(busy), 1);
      host_en = 1'b1; host_we = 1'b1; host_addr = 3'd3; host_wdata = 8'hEE;
      #1;
      check("R10", "err on write while busy", int'(host_err), 1);
      @(negedge clk);
      host_we = 1'b0; host_addr = 3'd4;
      #1;
      check("R10", "read while busy is zero", int'(host_rdata), 0);
      check("R10", "err on read while busy", int'(host_err), 1);
      host_en = 1'b0;
      sw_store = 1'b1;
      @(negedge clk);
      sw_store = 1'b0;
      wait_idle(nb, nd);
      @(negedge clk);
      check("R11", "store during busy dropped", int'(busy), 0);
      check("R11", "count unchanged", int'(store_count), 2);
      do_read(3, d, e);
      check("R10", "busy write ignored", d, 8'hA3);
   endtask

   task automatic t_auto_clean();
      @(negedge clk);
      supply_ok = 1'b0;
      @(negedge clk);
      check("R7", "no store when clean", int'(busy), 0);
      check("R7", "unpowered", int'(ready), 0);
      check("R7", "count kept", int'(store_count), 2);
   endtask

   task automatic t_auto_dirty();
      int nb, nd, d, e;
      @(negedge clk);
      supply_ok = 1'b0;
      host_en = 1'b1; host_we = 1'b1; host_addr = 3'd5; host_wdata = 8'h33;
      @(negedge clk);
      host_en = 1'b0; host_we = 1'b0;
      wait_idle(nb, nd);
      check("R6", "auto store busy cycles", nb, XC);
      check("R6", "unpowered after store", int'(ready), 0);
      check("R12", "count at limit", int'(store_count), LIM);
      check("R12", "wear flag", int'(wear_out), 1);
      t_power_up("R3");
      do_read(5, d, e);
      check("R6", "same-cycle write survives", d, 8'h33);
      pulse(1'b1, 1'b0, 1'b0);
      wait_idle(nb, nd);
      check("R12", "count saturates", int'(store_count), LIM);
   endtask

   task automatic t_priority();
      int nb, nd, d, e;
      do_write(1, 8'h77);
      pulse(1'b0, 1'b1, 1'b1);
      wait_idle(nb, nd);
      check("R11", "supply drop wins, unpowered", int'(ready), 0);
      t_power_up("R3");
      do_read(1, d, e);
      check("R11", "store beat recall on drop", d, 8'h77);
      do_write(0, 8'h11);
      pulse(1'b1, 1'b1, 1'b0);
      wait_idle(nb, nd);
      pulse(1'b0, 1'b1, 1'b0);
      wait_idle(nb, nd);
      do_read(0, d, e);
      check("R11", "store beats recall", d, 8'h11);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_power_up("R3");
      t_blank_fill();
      t_sw_store_recall();
      t_busy_access();
      t_auto_clean();
      t_power_up("R3");
      t_auto_dirty();
      t_priority();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog: actual=hung expected=complete");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule